// File: doc/BRIEF.md
# Programmable Down-Counting Reload Timer

This block is a 16-bit down-counter controlled through a small byte-wide register port. Software writes a 16-bit reload value in two byte writes, then uses a control register to choose the count source, a prescale ratio, single-pass or continuous operation, and an interrupt enable. It can also force an immediate reload-and-restart. The counter steps down on the prescaled system clock, on rising edges of an asynchronous GPIO event pin, or on rising edges of a real-time-clock tick.

When the count runs out, the block sets an end-of-count flag and can raise an interrupt request. In continuous mode the counter then reloads itself. In single-pass mode it parks at zero and switches itself off. The count and the reload value share the two data addresses: reads return the live count and writes go to the reload value. A read of the low byte freezes the high byte, so that a two-read sequence returns a coherent 16-bit value.

Register map (2-bit address): 0 = control (read/write), 1 = count low on read / reload low on write, 2 = count high on read / reload high on write, 3 = status (read only, bit 0 = end-of-count flag). Control fields: bit 0 run enable, bit 1 reload-and-restart strobe, bit 2 continuous mode, bits 4:3 prescale select, bits 6:5 source select, bit 7 interrupt enable.

Top module: `reload_timer`

## Requirements
- R1: The reload value is {byte written to address 2, byte written to address 1}. It is write-only: writing either byte never changes the count that reads return.
- R2: A read of address 1 returns count bits 7:0 and captures count bits 15:8 at that clock edge. A following read of address 2 returns the captured byte, even if the count changes in between.
- R3: A control write with bit 1 set loads the reload value into the counter at that same clock edge and restarts the prescaler. Bit 1 always reads back as 0.
- R4: With source 0 (system clock) and the run enable set, the count drops by one every 4, 16, 64 or 256 clocks for prescale select 0, 1, 2 or 3. The first step comes that many clocks after the control write, and the count holds between steps.
- R5: With source 1 (GPIO), each rising edge of the event pin decrements the count on the fifth rising clock edge after the pin edge, when pin high and low times are each at least two clocks.
- R6: The prescale select has no effect for source 1 or source 2 (RTC). With source 2, each rising edge of the RTC tick decrements the count once.
- R7: A step taken when the count is 1 or 0 is an end-of-count. In continuous mode (control bit 2 = 1), the counter takes the reload value at that edge.
- R8: In single-pass mode, an end-of-count leaves the count at 0 and clears the run enable, which reads back as 0.
- R9: An end-of-count sets status bit 0. A read of address 3 clears it unless a new end-of-count happens in the same cycle. The output irq equals the flag ANDed with control bit 7.
- R10: After reset the control register, count, reload value, flag and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (captures high byte, clears flag) |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from addr |
| gpio_evt | input | 1 | Asynchronous external event pin |
| rtc_evt | input | 1 | Real-time-clock tick, synchronous to clk |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a count that changes between the two byte reads. This would expose a torn 16-bit value. The stimulus reads the low byte and then fires a reload-and-restart write before the high-byte read, so the live count jumps to a different value while the captured byte must survive. The five-clock GPIO latency is also awkward to observe. The bench raises the pin between clock edges, reads the count after exactly four edges, when it must still be unchanged, and reads again after the fifth edge, when it must have dropped. Random prescale ratios, reload values and wait lengths cover the system-clock stepping.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_GPIO = 2'd1,
    SRC_RTC  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned DIV_STEPS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int unsigned PW = 2 * DIV_STEPS;

  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PW; i++) begin
      if (i < 2 * (int'(div_sel) + 1)) mask[i] = 1'b1;
    end
  end

  assign tick = run && !clear && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/timer_event_sync.sv
module timer_event_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pulse
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 edge_q, pulse_q;
  logic                 edge_c;

  assign edge_c = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign pulse  = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      edge_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-1:0], pin};
      edge_q  <= edge_c;
      pulse_q <= edge_q;
    end
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         cont,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         eoc
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         last;

  assign last  = (cnt_q <= W'(1));
  assign eoc   = step && !load && last;
  assign count = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = reload;
    else if (step) cnt_d = last ? (cont ? reload : '0) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              gpio_evt,
  input  logic              rtc_evt,
  output logic              irq
);
  localparam int unsigned HALF = CNT_W / 2;

  logic             en_q, en_d, cont_q, cont_d, ie_q, ie_d;
  logic [1:0]       div_q, div_d;
  src_e             src_q, src_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [HALF-1:0]  hold_q, hold_d;
  logic             flag_q, flag_d, rtc_q;

  logic             ctrl_wr, restart, presc_tick, gpio_pulse, rtc_rise, step, eoc;
  logic [CNT_W-1:0] count;

  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign restart  = ctrl_wr && wr_data[1];
  assign rtc_rise = rtc_evt && !rtc_q;

  timer_prescaler #(.DIV_STEPS(4)) i_presc (
    .clk(clk), .rst_n(rst_n), .run(en_q && (src_q == SRC_SYS)),
    .clear(ctrl_wr), .div_sel(div_q), .tick(presc_tick)
  );

  timer_event_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin(gpio_evt), .pulse(gpio_pulse)
  );

  always_comb begin
    case (src_q)
      SRC_SYS:  step = en_q && presc_tick;
      SRC_GPIO: step = en_q && gpio_pulse;
      SRC_RTC:  step = en_q && rtc_rise;
      default:  step = 1'b0;
    endcase
  end

  timer_counter #(.W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(restart), .step(step), .cont(cont_q),
    .reload(reload_q), .count(count), .eoc(eoc)
  );

  always_comb begin
    en_d = en_q; cont_d = cont_q; ie_d = ie_q; div_d = div_q; src_d = src_q;
    reload_d = reload_q; hold_d = hold_q; flag_d = flag_q;
    if (eoc && !cont_q) en_d = 1'b0;
    if (ctrl_wr) begin
      en_d   = wr_data[0];
      cont_d = wr_data[2];
      div_d  = wr_data[4:3];
      src_d  = src_e'(wr_data[6:5]);
      ie_d   = wr_data[7];
    end
    if (wr_en && addr == A_LO) reload_d[HALF-1:0]     = wr_data;
    if (wr_en && addr == A_HI) reload_d[CNT_W-1:HALF] = wr_data;
    if (rd_en && addr == A_LO) hold_d = count[CNT_W-1:HALF];
    if (rd_en && addr == A_STAT) flag_d = 1'b0;
    if (eoc) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; cont_q <= 1'b0; ie_q <= 1'b0; div_q <= '0; src_q <= SRC_SYS;
      reload_q <= '0; hold_q <= '0; flag_q <= 1'b0; rtc_q <= 1'b0;
    end else begin
      en_q <= en_d; cont_q <= cont_d; ie_q <= ie_d; div_q <= div_d; src_q <= src_d;
      reload_q <= reload_d; hold_q <= hold_d; flag_q <= flag_d; rtc_q <= rtc_evt;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {ie_q, src_q, div_q, cont_q, 1'b0, en_q};
      A_LO:    rd_data = count[HALF-1:0];
      A_HI:    rd_data = hold_q;
      default: rd_data = {7'd0, flag_q};
    endcase
  end

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/timer_checker.sv
module timer_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [15:0] count,
  input logic [15:0] reload,
  input logic        step,
  input logic        restart,
  input logic        eoc,
  input logic        cont,
  input logic        en,
  input logic        flag
);
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == $past(reload)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(count)); // R4
  AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && cont) |=> count == $past(reload)); // R7
  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cont && !(wr_en && addr == 2'd0)) |=> (!en && count == 16'd0)); // R8
  AST_EOC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> flag); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3 && !eoc) |=> !flag); // R9
endmodule

bind reload_timer timer_checker i_timer_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .count(count), .reload(reload_q), .step(step), .restart(restart),
  .eoc(eoc), .cont(cont_q), .en(en_q), .flag(flag_q)
);

// File: tb/test_reload_timer.sv
module test_reload_timer;
  logic       clk, rst_n, wr_en, rd_en, gpio_evt, rtc_evt, irq;
  logic [1:0] addr;
  logic [7:0] wr_data, rd_data;
  int checks, fails;
  bit done;

  reload_timer i_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .gpio_evt(gpio_evt), .rtc_evt(rtc_evt), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int unsigned div_of(input int unsigned sel);
    return 4 << (2 * sel);
  endfunction
  function automatic logic [15:0] exp_count(input logic [15:0] rl, input int unsigned k, input int unsigned sel);
    return rl - 16'(k / div_of(sel));
  endfunction
  function automatic logic [7:0] ctrl_byte(input bit en, restart, cont, input int unsigned div, src, input bit ie);
    return {ie, 2'(src), 2'(div), cont, restart, en};
  endfunction

  task automatic check(input string req, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask
  task automatic rd1(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rd_data;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask
  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd1(2'd1, lo); rd1(2'd2, hi); v = {hi, lo};
  endtask
  task automatic set_reload(input logic [15:0] v);
    wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, rl;
    logic [7:0] b;
    int unsigned k, sel;
    void'($urandom(32'd1234));
    checks = 0; fails = 0;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0; gpio_evt = 0; rtc_evt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    rd1(2'd0, b); check("R10 ctrl", {8'd0, b}, 16'd0);
    rd_cnt(v); check("R10 count", v, 16'd0);
    rd1(2'd3, b); check("R10 flag", {8'd0, b}, 16'd0);
    check("R10 irq", {15'd0, irq}, 16'd0);

    // R1 / R3: load, write-only reload, restart
    set_reload(16'h1234); wr(2'd0, ctrl_byte(0, 1, 0, 0, 0, 0));
    rd_cnt(v); check("R3 restart load", v, 16'h1234);
    rd1(2'd0, b); check("R3 bit1 reads 0", {8'd0, b}, 16'd0);
    set_reload(16'hABCD);
    rd_cnt(v); check("R1 reload write-only", v, 16'h1234);

    // R2 coherent read across a restart
    rd1(2'd1, b); check("R2 low", {8'd0, b}, 16'h0034);
    wr(2'd0, ctrl_byte(0, 1, 0, 0, 0, 0));
    rd1(2'd2, b); check("R2 held high", {8'd0, b}, 16'h0012);
    rd_cnt(v); check("R1 R2 new count", v, 16'hABCD);

    // R4 random prescale stepping
    for (int i = 0; i < 20; i++) begin
      sel = $urandom % 4;
      rl = 16'(2000 + ($urandom % 60000));
      k = $urandom % 400;
      set_reload(rl);
      wr(2'd0, ctrl_byte(1, 1, 0, sel, 0, 0));
      repeat (k) @(posedge clk);
      rd_cnt(v); check("R4 prescaled step", v, exp_count(rl, k, sel));
      wr(2'd0, 8'd0);
    end
    // R4 directed: one clock before and at the first step with /4
    set_reload(16'd500); wr(2'd0, ctrl_byte(1, 1, 0, 0, 0, 0));
    repeat (3) @(posedge clk);
    rd_cnt(v); check("R4 before first step", v, 16'd500);
    wr(2'd0, ctrl_byte(1, 1, 0, 0, 0, 0));
    repeat (4) @(posedge clk);
    rd_cnt(v); check("R4 first step", v, 16'd499);
    wr(2'd0, 8'd0);

    // R5 / R6 GPIO source, five-clock latency, prescaler ignored
    set_reload(16'd100); wr(2'd0, ctrl_byte(1, 1, 0, 3, 1, 0));
    @(negedge clk); gpio_evt = 1'b1;
    repeat (4) @(posedge clk);
    rd_cnt(v); check("R5 unchanged after 4 edges", v, 16'd100);
    rd_cnt(v); check("R5 step on fifth edge", v, 16'd99);
    @(negedge clk); gpio_evt = 1'b0;
    for (int i = 0; i < 3; i++) begin
      repeat (2) @(negedge clk); gpio_evt = 1'b1;
      repeat (2) @(negedge clk); gpio_evt = 1'b0;
    end
    repeat (8) @(posedge clk);
    rd_cnt(v); check("R5 R6 gpio pulses", v, 16'd96);
    wr(2'd0, 8'd0);

    // R6 RTC source
    set_reload(16'd50); wr(2'd0, ctrl_byte(1, 1, 0, 2, 2, 0));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rtc_evt = 1'b1;
      @(negedge clk); rtc_evt = 1'b0;
      @(negedge clk);
    end
    rd_cnt(v); check("R6 rtc steps", v, 16'd46);
    wr(2'd0, 8'd0);

    // R7 / R9 continuous end-of-count with irq
    set_reload(16'd3); wr(2'd0, ctrl_byte(1, 1, 1, 0, 0, 1));
    repeat (13) @(posedge clk);
    rd_cnt(v); check("R7 reloaded", v, 16'd3);
    check("R9 irq high", {15'd0, irq}, 16'd1);
    rd1(2'd3, b); check("R9 flag set", {8'd0, b}, 16'd1);
    rd1(2'd3, b); check("R9 flag cleared", {8'd0, b}, 16'd0);
    check("R9 irq low", {15'd0, irq}, 16'd0);
    wr(2'd0, 8'd0);

    // R8 single-pass
    set_reload(16'd2); wr(2'd0, ctrl_byte(1, 1, 0, 0, 0, 0));
    repeat (20) @(posedge clk);
    rd_cnt(v); check("R8 parked at zero", v, 16'd0);
    rd1(2'd0, b); check("R8 enable cleared", {15'd0, b[0]}, 16'd0);
    rd1(2'd3, b); check("R8 R9 flag set", {8'd0, b}, 16'd1);
    check("R9 irq masked", {15'd0, irq}, 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule